// File: doc/BRIEF.md
# Serial Configuration Word Programmer

This block is the host side of a three-wire configuration link to a programmable clock synthesizer. When a load is requested, it captures a 160-bit configuration word from a parallel input. It then clocks the word out serially, most significant bit first, on a serial clock and data pair. Next it raises a strobe so the target commits the word to its output latch. Finally it releases an active-low output-disable line and waits out a lock interval before reporting completion.

The target's latch is transparent while the strobe is high. The controller therefore keeps the strobe low for the whole shift and never moves the serial clock while the strobe is high. Each minimum time the target needs is given as a parameter in picoseconds. These are data setup, data hold, the serial clock period, the gap before the strobe and the strobe width. The block rounds each one up to whole system-clock cycles. The lock wait is a parameter given in cycles. A `busy_o` level and a one-cycle `done_o` pulse form the handshake with the requester.

Top module: `cfg_word_loader`

## Requirements
- R1: After each load, exactly 160 serial clock rising edges occur before the strobe rises. The bits go out MSB first, so the word the target latches equals the word that was captured.
- R2: `word_i` is sampled only in the cycle a load is accepted. Later changes to `word_i` do not alter the word that is shifted.
- R3: A load is accepted only when `start_i` is high while `busy_o` is low. `busy_o` is high from the cycle after acceptance until `done_o` pulses. A `start_i` pulse while busy starts no second transfer.
- R4: `strobe_o` stays low while bits are being shifted. `sclk_o` has no edge while `strobe_o` is high. `sclk_o` idles low.
- R5: `data_o` changes only while `sclk_o` is low. It is stable for at least SETUP_PS before each `sclk_o` rising edge and for at least HOLD_PS after it.
- R6: Successive `sclk_o` rising edges are at least SCLK_MIN_PERIOD_PS apart.
- R7: `strobe_o` rises at least GAP_PS after the last `sclk_o` falling edge and stays high for at least STROBE_PS.
- R8: `out_en_o` goes low when a load is accepted and stays low until the strobe pulse ends. It rises in the same cycle that `strobe_o` falls, and it stays high afterwards while idle.
- R9: `done_o` is a single-cycle pulse exactly LOCK_CYCLES cycles after `strobe_o` falls. `busy_o` is low in that cycle.
- R10: After reset, `sclk_o`, `data_o`, `strobe_o`, `out_en_o`, `busy_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load request, accepted while idle |
| word_i | input | WORD_W | Configuration word, captured on acceptance |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock to the target |
| data_o | output | 1 | Serial data to the target, MSB first |
| strobe_o | output | 1 | Commit strobe to the target latch |
| out_en_o | output | 1 | Output-disable line, active low |

## Verification
The bench builds the block with a 5000 ps system clock and the default timing parameters. The bit phases therefore come out at 4 low and 4 high cycles, the gap at 2 cycles and the strobe at 8 cycles. This places every setup, hold, period, gap and width check close to its limit. LOCK_CYCLES is cut to 40, which makes the exact distance from strobe fall to `done_o` measurable within a short run; at the default length it would be out of reach. The word width stays at 160, so the bench's model of the target counts the real number of bits and latches the full word.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BIT_LO, ST_BIT_HI, ST_GAP, ST_STROBE, ST_LOCK
  } ld_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfg_shift_reg.sv
`timescale 1ns/1ps
module cfg_shift_reg #(
  parameter int WIDTH = 160
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             shift_i,
  output logic             msb_o
);
  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (cap_i)   sr_q <= word_i;
    else if (shift_i) sr_q <= {sr_q[WIDTH-2:0], 1'b0};
  end

  assign msb_o = sr_q[WIDTH-1];
endmodule

// File: rtl/cfg_phase_timer.sv
`timescale 1ns/1ps
module cfg_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_word_loader.sv
`timescale 1ns/1ps
module cfg_word_loader
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W             = 160,
  parameter int CLK_PERIOD_PS      = 5000,
  parameter int SETUP_PS           = 10000,
  parameter int HOLD_PS            = 10000,
  parameter int GAP_PS             = 10000,
  parameter int STROBE_PS          = 40000,
  parameter int SCLK_MIN_PERIOD_PS = 33334,
  parameter int LOCK_CYCLES        = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              data_o,
  output logic              strobe_o,
  output logic              out_en_o
);
  localparam int HALF_PS  = (SCLK_MIN_PERIOD_PS + 1) / 2;
  localparam int LO_CYC   = max2(1, max2(ceil_div(SETUP_PS, CLK_PERIOD_PS), ceil_div(HALF_PS, CLK_PERIOD_PS)));
  localparam int HI_CYC   = max2(1, max2(ceil_div(HOLD_PS, CLK_PERIOD_PS), ceil_div(HALF_PS, CLK_PERIOD_PS)));
  localparam int GAP_CYC  = max2(1, ceil_div(GAP_PS, CLK_PERIOD_PS));
  localparam int STB_CYC  = max2(1, ceil_div(STROBE_PS, CLK_PERIOD_PS));
  localparam int LOCK_CYC = max2(1, LOCK_CYCLES);
  localparam int MAX_CYC  = max2(max2(LO_CYC, HI_CYC), max2(max2(GAP_CYC, STB_CYC), LOCK_CYC));
  localparam int TMR_W    = $clog2(MAX_CYC + 1);
  localparam int BIT_W    = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  ld_state_e        st_q, st_d;
  logic             sclk_q, sclk_d, stb_q, stb_d, oe_q, oe_d;
  logic             busy_q, busy_d, done_q, done_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             tmr_load, tmr_zero, cap, shift;
  logic [TMR_W-1:0] tmr_val;

  cfg_shift_reg #(.WIDTH(WORD_W)) u_sreg (
    .clk_i, .rst_ni, .cap_i(cap), .word_i, .shift_i(shift), .msb_o(data_o)
  );

  cfg_phase_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  always_comb begin
    st_d = st_q; sclk_d = sclk_q; stb_d = stb_q; oe_d = oe_q;
    busy_d = busy_q; done_d = 1'b0; bit_d = bit_q;
    tmr_load = 1'b0; tmr_val = '0; cap = 1'b0; shift = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        cap = 1'b1; busy_d = 1'b1; oe_d = 1'b0; bit_d = '0;
        st_d = ST_BIT_LO; tmr_load = 1'b1; tmr_val = TMR_W'(LO_CYC - 1);
      end
      ST_BIT_LO: if (tmr_zero) begin
        sclk_d = 1'b1; st_d = ST_BIT_HI;
        tmr_load = 1'b1; tmr_val = TMR_W'(HI_CYC - 1);
      end
      ST_BIT_HI: if (tmr_zero) begin
        sclk_d = 1'b0; shift = 1'b1; tmr_load = 1'b1;
        if (bit_q == LAST_BIT) begin
          st_d = ST_GAP; tmr_val = TMR_W'(GAP_CYC - 1);
        end else begin
          bit_d = bit_q + 1'b1; st_d = ST_BIT_LO; tmr_val = TMR_W'(LO_CYC - 1);
        end
      end
      ST_GAP: if (tmr_zero) begin
        stb_d = 1'b1; st_d = ST_STROBE;
        tmr_load = 1'b1; tmr_val = TMR_W'(STB_CYC - 1);
      end
      ST_STROBE: if (tmr_zero) begin
        stb_d = 1'b0; oe_d = 1'b1; st_d = ST_LOCK;  // release only once committed
        tmr_load = 1'b1; tmr_val = TMR_W'(LOCK_CYC - 1);
      end
      ST_LOCK: if (tmr_zero) begin
        done_d = 1'b1; busy_d = 1'b0; st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; sclk_q <= 1'b0; stb_q <= 1'b0; oe_q <= 1'b0;
      busy_q <= 1'b0; done_q <= 1'b0; bit_q <= '0;
    end else begin
      st_q <= st_d; sclk_q <= sclk_d; stb_q <= stb_d; oe_q <= oe_d;
      busy_q <= busy_d; done_q <= done_d; bit_q <= bit_d;
    end
  end

  assign sclk_o   = sclk_q;
  assign strobe_o = stb_q;
  assign out_en_o = oe_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  assert_no_sclk_under_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (!sclk_o && $stable(sclk_o)));
  assert_data_stable_at_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(data_o));
  assert_oe_follows_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_o) |-> $fell(strobe_o));
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_not_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_start_busy_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o));
endmodule

// File: tb/cfg_word_loader_tb.sv
`timescale 1ns/1ps
module cfg_word_loader_tb;
  localparam int W = 160;
  localparam int LOCK = 40;
  localparam int T_PS = 5000;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic busy_o, done_o, sclk_o, data_o, strobe_o, out_en_o;

  cfg_word_loader #(.WORD_W(W), .CLK_PERIOD_PS(T_PS), .LOCK_CYCLES(LOCK)) u_dut (
    .clk_i, .rst_ni, .start_i, .word_i, .busy_o, .done_o,
    .sclk_o, .data_o, .strobe_o, .out_en_o
  );

  always #2.5 clk_i = ~clk_i;

  int vecs = 0, fails = 0, cyc = 0, pushes = 0, strobes = 0, dones = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) cyc <= cyc + 1;

  // target model and timing monitor
  logic [W-1:0] tgt_sr = '0, tgt_latch = '0;
  int nbits = 0, t_data = -1000, t_rise = -1000, t_fall = -1000, t_srise = 0, t_sfall = 0;
  logic p_sclk = 0, p_data = 0, p_stb = 0, p_oe = 0, p_done = 0;

  always @(negedge clk_i) if (rst_ni) begin
    if (sclk_o != p_sclk && p_stb)
      chk(1'b0, "R4 sclk edge under strobe", W'(sclk_o), W'(p_sclk));
    if (data_o != p_data) begin
      chk(!sclk_o, "R5 data moved with sclk high", W'(sclk_o), '0);
      chk((cyc - t_rise) * T_PS >= 10000, "R5 hold", W'((cyc - t_rise) * T_PS), W'(10000));
      t_data = cyc;
    end
    if (sclk_o && !p_sclk) begin
      chk(!strobe_o, "R4 strobe low during shift", W'(strobe_o), '0);
      chk(!out_en_o, "R8 out_en low during shift", W'(out_en_o), '0);
      chk((cyc - t_data) * T_PS >= 10000, "R5 setup", W'((cyc - t_data) * T_PS), W'(10000));
      if (nbits > 0)
        chk((cyc - t_rise) * T_PS >= 33334, "R6 sclk period", W'((cyc - t_rise) * T_PS), W'(33334));
      tgt_sr = {tgt_sr[W-2:0], data_o};
      nbits++;
      t_rise = cyc;
    end
    if (!sclk_o && p_sclk) t_fall = cyc;
    if (strobe_o && !p_stb) begin
      chk(nbits == W, "R1 bit count", W'(nbits), W'(W));
      chk((cyc - t_fall) * T_PS >= 10000, "R7 gap", W'((cyc - t_fall) * T_PS), W'(10000));
      t_srise = cyc;
    end
    if (strobe_o) tgt_latch = tgt_sr;
    if (!strobe_o && p_stb) begin
      strobes++;
      chk((cyc - t_srise) * T_PS >= 40000, "R7 strobe width", W'((cyc - t_srise) * T_PS), W'(40000));
      chk(out_en_o, "R8 out_en rises with strobe fall", W'(out_en_o), W'(1));
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected commit", tgt_latch, '0);
      else begin
        automatic logic [W-1:0] e = exp_q.pop_front();
        chk(tgt_latch == e, "R1 R2 latched word", tgt_latch, e);
      end
      nbits = 0;
      t_sfall = cyc;
    end
    if (out_en_o && !p_oe && !(p_stb && !strobe_o))
      chk(1'b0, "R8 out_en rose without strobe", W'(out_en_o), '0);
    if (done_o) begin
      dones++;
      chk(!p_done, "R9 done single cycle", W'(p_done), '0);
      chk(cyc - t_sfall == LOCK, "R9 lock wait", W'(cyc - t_sfall), W'(LOCK));
      chk(!busy_o, "R9 busy low at done", W'(busy_o), '0);
    end
    p_sclk = sclk_o; p_data = data_o; p_stb = strobe_o; p_oe = out_en_o; p_done = done_o;
  end

  task automatic load_word(input logic [W-1:0] w, input bit poke_busy);
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    start_i = 1'b1; word_i = w;
    exp_q.push_back(w); pushes++;
    @(negedge clk_i);
    start_i = 1'b0;
    word_i = ~w;  // R2: must not matter after capture
    chk(busy_o, "R3 busy after accept", W'(busy_o), W'(1));
    if (poke_busy) begin
      repeat (300) @(negedge clk_i);
      start_i = 1'b1; word_i = {W/8{8'h3C}};
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
    chk(!busy_o && out_en_o && !sclk_o && !strobe_o, "R8 R4 idle after done",
        W'({busy_o, out_en_o, sclk_o, strobe_o}), W'(4'b0100));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk({sclk_o, data_o, strobe_o, out_en_o, busy_o, done_o} == 6'b0, "R10 reset state",
        W'({sclk_o, data_o, strobe_o, out_en_o, busy_o, done_o}), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({sclk_o, strobe_o, out_en_o, busy_o} == 4'b0, "R10 idle after reset",
        W'({sclk_o, strobe_o, out_en_o, busy_o}), '0);
    load_word({W{1'b1}}, 1'b0);
    load_word('0, 1'b0);
    load_word({W/32{32'hA5C3_0F96}}, 1'b1);
    begin
      automatic logic [W-1:0] w = '0;
      for (int i = 0; i < W; i++) w[i] = ((i * 7) % 3) == 0;
      load_word(w, 1'b0);
    end
    load_word({1'b1, {W-1{1'b0}}}, 1'b0);
    repeat (LOCK + 20) @(negedge clk_i);
    chk(exp_q.size() == 0, "R3 queue drained", W'(exp_q.size()), '0);
    chk(strobes == pushes, "R3 commits equal accepted loads", W'(strobes), W'(pushes));
    chk(dones == pushes, "R9 one done per load", W'(dones), W'(pushes));
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule